// File: doc/BRIEF.md
# Wearable Alarm Node Controller

This block sequences a small wearable alarm node that talks over a byte-wide radio link. After reset it waits for the radio to report ready, blinking the red lamp while it waits. It then broadcasts a boot byte that carries its 6-bit node ID, once per handshake period, until a received byte matches that boot byte exactly. The node is then active. It shows a steady green lamp, watches the radio for alarm bytes from other nodes, and watches a wearer-operated distress button.

A button press latches a distress state until reset. In that state the node sends an alarm byte at once and again every five seconds, and it toggles the buzzer and strobe every half second. An alarm byte received from another node while active latches an alert mode, in which the vibration motor toggles every half second. The UART and the radio sit outside the block. It sees received bytes as a valid/data pair and hands bytes to transmit through a valid/ready pair. All intervals are counted in quarter-seconds of a prescaled tick, sized from the clock frequency parameter.

Top module: `alarm_node_ctrl`

## Requirements
- R1: Every transmitted byte carries the node ID in bits 5:0. A boot byte has bits 7:6 = 01 (0x40 | ID) and an alarm byte has bits 7:6 = 11 (0xC0 | ID).
- R2: While waiting for radio-ready, the green lamp is off and the red lamp is on for 1 s and then off for 1 s, repeating. The wait phase starts with the lamp on.
- R3: When radio-ready is seen, the node enters boot and requests a boot byte in the same cycle. A further boot byte falls due every 1.5 s. Each period shows the red lamp alone for the first 0.75 s and the green lamp alone for the second 0.75 s.
- R4: In boot, a received byte equal to the boot byte moves the node to active, where green is steadily on and red is off. Any other byte leaves boot unchanged. No boot byte is sent after the node leaves boot.
- R5: A requested byte appears on tx_valid/tx_data and stays unchanged until a cycle with tx_ready high. A send that falls due while an earlier byte is still waiting is dropped, not queued.
- R6: The distress button passes through a two-stage synchronizer and is acted on only on a rising edge. Edges before the node is active (wait and boot) have no effect.
- R7: Distress is kept until reset, with red on and green off. Received bytes and further button edges have no effect in distress.
- R8: On entering distress an alarm byte is requested at once, and another every 5 s after that.
- R9: In distress the buzzer and strobe start low and toggle together every 0.5 s. Outside distress they do not change.
- R10: In active, a received byte with bits 7:6 = 11 enters alert mode. There the vibration output toggles every 0.5 s, further received bytes are ignored, and a button edge still enters distress.
- R11: When a button edge and an alarm byte arrive in the same cycle in active, distress wins.
- R12: During and right after reset, the state is wait, red is on, and green, buzzer, strobe, vibration and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| node_id | input | ID_W (6) | Node identifier placed in bits 5:0 of every byte |
| radio_ready | input | 1 | Radio powered and ready |
| distress_btn | input | 1 | Asynchronous distress button, active high |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | ID_W+2 (8) | Received byte |
| tx_ready | input | 1 | Transmitter accepts the byte on tx_data |
| tx_valid | output | 1 | A byte is waiting to be sent |
| tx_data | output | ID_W+2 (8) | Byte to send |
| lamp_green | output | 1 | Green indicator lamp |
| lamp_red | output | 1 | Red indicator lamp |
| buzzer | output | 1 | Buzzer drive |
| strobe | output | 1 | Strobe drive |
| vibe | output | 1 | Vibration motor drive |

## Verification
A wrong state shows first on the lamps, because each state has its own lamp pattern. A node stuck in boot shows red in the first half of every period, where active shows steady green. A falsely entered distress shows red within one cycle, and an alarm byte appears on tx_valid in the same cycle. A phase counter that is off by one shifts the lamp, buzzer or vibration edges by a quarter-second, which is visible within the next half-second. A lost or duplicated transmit shows as a wrong count of tx handshakes within one 1.5 s or 5 s period.

// File: rtl/anc_pkg.sv
package anc_pkg;

  typedef enum logic [2:0] {
    ST_WAIT     = 3'd0,
    ST_BOOT     = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_ALERT    = 3'd3,
    ST_DISTRESS = 3'd4
  } state_e;

  // Upper two bits of a packet select its kind; the node ID fills the rest.
  localparam logic [1:0] TAG_BOOT  = 2'b01;
  localparam logic [1:0] TAG_ALARM = 2'b11;

endpackage

// File: rtl/anc_tick.sv
module anc_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = !restart && (cnt_q == LAST);
endmodule

// File: rtl/anc_edge_sync.sv
module anc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/anc_tx_hold.sv
module anc_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] req_data,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q, data_d;
  logic         load;

  // A request is taken only when the slot is free or empties this cycle.
  assign load = req && (!valid_q || tx_ready);

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (load) begin
      valid_d = 1'b1;
      data_d  = req_data;
    end else if (valid_q && tx_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;
endmodule

// File: rtl/alarm_node_ctrl.sv
module alarm_node_ctrl
  import anc_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned QTR_CYCLES = CLK_HZ / 4,
  parameter int unsigned ID_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic              radio_ready,
  input  logic              distress_btn,
  input  logic              rx_valid,
  input  logic [ID_W+1:0]   rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [ID_W+1:0]   tx_data,
  output logic              lamp_green,
  output logic              lamp_red,
  output logic              buzzer,
  output logic              strobe,
  output logic              vibe
);
  localparam int unsigned PKT_W   = ID_W + 2;
  // Intervals in quarter-second ticks.
  localparam int unsigned HALF_Q  = 2;   // 0.5 s
  localparam int unsigned HS_Q    = 3;   // 0.75 s
  localparam int unsigned BLINK_Q = 4;   // 1 s
  localparam int unsigned ALARM_Q = 20;  // 5 s
  localparam int unsigned PH_W    = $clog2(ALARM_Q + 2 * BLINK_Q);

  localparam logic [PH_W-1:0] WRAP_WAIT  = PH_W'(2 * BLINK_Q - 1);
  localparam logic [PH_W-1:0] WRAP_BOOT  = PH_W'(2 * HS_Q - 1);
  localparam logic [PH_W-1:0] WRAP_ALERT = PH_W'(2 * HALF_Q - 1);
  localparam logic [PH_W-1:0] WRAP_DIST  = PH_W'(ALARM_Q - 1);
  localparam logic [PH_W-1:0] BLINK_ON   = PH_W'(BLINK_Q);
  localparam logic [PH_W-1:0] HS_SPLIT   = PH_W'(HS_Q);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  state_e           state_q, state_d;
  logic [PH_W-1:0]  ph_q, ph_d, ph_wrap;
  logic             restart, tick, btn_rise, half_edge;
  logic             send_req;
  logic [PKT_W-1:0] send_data, boot_pkt, alarm_pkt;
  logic             buzz_q, buzz_d, strb_q, strb_d, vibe_q, vibe_d;
  logic             rx_is_alarm;

  assign boot_pkt    = {TAG_BOOT, node_id};
  assign alarm_pkt   = {TAG_ALARM, node_id};
  assign rx_is_alarm = rx_valid && (rx_data[PKT_W-1:PKT_W-2] == TAG_ALARM);

  anc_tick #(.DIV(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart), .tick(tick)
  );

  anc_edge_sync #(.STAGES(2)) u_btn (
    .clk(clk), .rst_n(rst_sync_n), .din(distress_btn), .rise(btn_rise)
  );

  anc_tx_hold #(.W(PKT_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .req(send_req), .req_data(send_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  // Next state and send requests.
  always_comb begin
    state_d   = state_q;
    send_req  = 1'b0;
    send_data = alarm_pkt;
    unique case (state_q)
      ST_WAIT: begin
        if (radio_ready) begin
          state_d   = ST_BOOT;
          send_req  = 1'b1;
          send_data = boot_pkt;
        end
      end
      ST_BOOT: begin
        if (rx_valid && rx_data == boot_pkt) begin
          state_d = ST_ACTIVE;
        end else if (tick && ph_q == WRAP_BOOT) begin
          send_req  = 1'b1;
          send_data = boot_pkt;
        end
      end
      ST_ACTIVE: begin
        if (btn_rise) begin
          state_d  = ST_DISTRESS;
          send_req = 1'b1;
        end else if (rx_is_alarm) begin
          state_d = ST_ALERT;
        end
      end
      ST_ALERT: begin
        if (btn_rise) begin
          state_d  = ST_DISTRESS;
          send_req = 1'b1;
        end
      end
      ST_DISTRESS: begin
        if (tick && ph_q == WRAP_DIST) send_req = 1'b1;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  assign restart = (state_d != state_q);

  always_comb begin
    unique case (state_q)
      ST_WAIT:     ph_wrap = WRAP_WAIT;
      ST_BOOT:     ph_wrap = WRAP_BOOT;
      ST_ALERT:    ph_wrap = WRAP_ALERT;
      ST_DISTRESS: ph_wrap = WRAP_DIST;
      default:     ph_wrap = '0;
    endcase
  end

  always_comb begin
    if (restart)   ph_d = '0;
    else if (tick) ph_d = (ph_q == ph_wrap) ? '0 : ph_q + 1'b1;
    else           ph_d = ph_q;
  end

  assign half_edge = tick && ((32'(ph_q) % HALF_Q) == (HALF_Q - 1));

  always_comb begin
    buzz_d = buzz_q;
    strb_d = strb_q;
    vibe_d = vibe_q;
    if (state_q == ST_DISTRESS && half_edge) begin
      buzz_d = ~buzz_q;
      strb_d = ~strb_q;
    end
    if (state_q == ST_ALERT && half_edge) vibe_d = ~vibe_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_WAIT;
      ph_q    <= '0;
      buzz_q  <= 1'b0;
      strb_q  <= 1'b0;
      vibe_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      buzz_q  <= buzz_d;
      strb_q  <= strb_d;
      vibe_q  <= vibe_d;
    end
  end

  always_comb begin
    lamp_red   = 1'b0;
    lamp_green = 1'b0;
    unique case (state_q)
      ST_WAIT:     lamp_red = (ph_q < BLINK_ON);
      ST_BOOT: begin
        lamp_red   = (ph_q < HS_SPLIT);
        lamp_green = (ph_q >= HS_SPLIT);
      end
      ST_ACTIVE,
      ST_ALERT:    lamp_green = 1'b1;
      ST_DISTRESS: lamp_red = 1'b1;
      default:     lamp_red = 1'b0;
    endcase
  end

  assign buzzer = buzz_q;
  assign strobe = strb_q;
  assign vibe   = vibe_q;
endmodule

// File: rtl/anc_chk.sv
module anc_chk
  import anc_pkg::*;
#(
  parameter int unsigned ID_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input state_e          state,
  input logic [ID_W-1:0] node_id,
  input logic            rx_valid,
  input logic [ID_W+1:0] rx_data,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [ID_W+1:0] tx_data,
  input logic            lamp_red,
  input logic            lamp_green,
  input logic            buzzer,
  input logic            vibe
);
  p_pkt_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == {TAG_BOOT, node_id} || tx_data == {TAG_ALARM, node_id}));

  p_lamps_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lamp_red, lamp_green}));

  p_echo_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && $past(state) == ST_BOOT)
      |-> ($past(rx_valid) && $past(rx_data) == {TAG_BOOT, node_id}));

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_distress_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DISTRESS) |=> (state == ST_DISTRESS));

  p_buzz_only_distress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buzzer) |-> ($past(state) == ST_DISTRESS));

  p_vibe_only_alert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vibe) |-> ($past(state) == ST_ALERT));
endmodule

bind alarm_node_ctrl anc_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .state(state_q), .node_id(node_id),
  .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .lamp_red(lamp_red),
  .lamp_green(lamp_green), .buzzer(buzzer), .vibe(vibe)
);

// File: tb/sim_alarm_node_ctrl.sv
module sim_alarm_node_ctrl;
  localparam int unsigned Q = 8;
  localparam logic [5:0] NID = 6'h2A;
  localparam logic [7:0] BOOT_B  = 8'h6A;
  localparam logic [7:0] ALARM_B = 8'hEA;

  logic clk = 1'b0;
  logic rst_n, radio_ready, distress_btn, rx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;
  logic tx_valid, lamp_green, lamp_red, buzzer, strobe, vibe;

  always #4 clk = ~clk;

  alarm_node_ctrl #(.QTR_CYCLES(Q)) u0 (
    .clk(clk), .rst_n(rst_n), .node_id(NID), .radio_ready(radio_ready),
    .distress_btn(distress_btn), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .lamp_green(lamp_green), .lamp_red(lamp_red), .buzzer(buzzer),
    .strobe(strobe), .vibe(vibe)
  );

  int n_chk = 0, n_fail = 0, hs_cnt = 0;
  logic [7:0] hs_last = 8'h00;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n && tx_valid && tx_ready) begin
    hs_cnt  <= hs_cnt + 1;
    hs_last <= tx_data;
  end

  // {received byte, expect alert}; alarm tag is bits 7:6 = 11
  localparam logic [8:0] VEC [8] = '{
    {8'hC0, 1'b1}, {8'hC5, 1'b1}, {8'hFF, 1'b1}, {8'h80, 1'b0},
    {8'h40, 1'b0}, {8'h7F, 1'b0}, {8'h00, 1'b0}, {8'hBF, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_valid = 1'b0; distress_btn = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic go_active();
    do_reset();
    radio_ready = 1'b1; tx_ready = 1'b1;
    wait_n(6);
    send_rx(BOOT_B);
    wait_n(2);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; radio_ready = 1'b0; distress_btn = 1'b0;
    rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b0;

    // Reset state and wait phase
    do_reset();
    wait_n(1);
    chk(lamp_red && !lamp_green && !tx_valid && !buzzer && !strobe && !vibe, "R12 reset outputs",
        {lamp_red, lamp_green, tx_valid, buzzer, strobe, vibe}, 6'b100000);
    wait_n(5);
    chk(lamp_red && !lamp_green, "R2 wait red on", {lamp_red, lamp_green}, 2'b10);
    wait_n(4); distress_btn = 1'b1;   // R6: edge before active
    wait_n(10); distress_btn = 1'b0;
    wait_n(18);
    chk(!lamp_red && !lamp_green, "R2 R6 wait red off, button ignored", {lamp_red, lamp_green}, 2'b00);
    wait_n(32);
    chk(lamp_red && !tx_valid, "R2 wait red on again", {lamp_red, tx_valid}, 2'b10);

    // Boot
    wait_n(2); radio_ready = 1'b1;
    wait_n(1);  // c=1
    chk(tx_valid && tx_data == BOOT_B, "R1 R3 boot byte requested", tx_data, BOOT_B);
    wait_n(3);  // c=4
    chk(lamp_red && !lamp_green, "R3 boot first half red", {lamp_red, lamp_green}, 2'b10);
    wait_n(4); distress_btn = 1'b1;   // c=8
    wait_n(8); distress_btn = 1'b0;   // c=16
    wait_n(12); // c=28
    chk(lamp_green && !lamp_red, "R3 R6 boot second half green", {lamp_red, lamp_green}, 2'b01);
    wait_n(24); // c=52
    chk(tx_valid && tx_data == BOOT_B && hs_cnt == 0, "R5 byte held without ready", tx_data, BOOT_B);
    tx_ready = 1'b1;
    wait_n(1);  // c=53
    chk(!tx_valid && hs_cnt == 1, "R5 due send dropped while pending", hs_cnt, 1);
    wait_n(7);  // c=60
    send_rx(8'h6B); // c=61
    wait_n(3);  // c=64
    chk(lamp_red && !lamp_green, "R4 wrong echo keeps boot", {lamp_red, lamp_green}, 2'b10);
    wait_n(6);  // c=70
    send_rx(BOOT_B);
    wait_n(1);
    chk(lamp_green && !lamp_red, "R4 echo enters active", {lamp_red, lamp_green}, 2'b01);
    base = hs_cnt;
    wait_n(14 * Q);
    chk(hs_cnt == base && lamp_green, "R4 no boot resend after active", hs_cnt, base);

    // Table of received bytes in active
    foreach (VEC[i]) begin
      go_active();
      base = hs_cnt;
      send_rx(VEC[i][8:1]);
      wait_n(2 * Q + 3);
      chk(vibe == VEC[i][0], "R10 alarm tag selects alert", vibe, VEC[i][0]);
      chk(lamp_green && !lamp_red && !buzzer, "R10 lamps in active/alert", {lamp_red, lamp_green, buzzer}, 3'b010);
      chk(hs_cnt == base, "R10 no transmit on received byte", hs_cnt, base);
    end

    // Alert ignores bytes, then distress
    go_active();
    send_rx(8'hC1);          // c=1
    wait_n(19);              // c=20
    chk(vibe, "R10 vibe first toggle", vibe, 1);
    wait_n(4);               // c=24
    send_rx(8'hC1);          // c=25
    wait_n(11);              // c=36
    chk(!vibe, "R10 later byte ignored, vibe period kept", vibe, 0);
    wait_n(4);               // c=40
    base = hs_cnt;
    distress_btn = 1'b1;
    wait_n(3);               // distress c=1
    wait_n(3);               // c=4
    chk(lamp_red && !lamp_green && !buzzer, "R7 R10 button enters distress", {lamp_red, lamp_green, buzzer}, 3'b100);
    chk(hs_cnt == base + 1 && hs_last == ALARM_B, "R1 R8 alarm sent on entry", hs_last, ALARM_B);
    distress_btn = 1'b0;
    wait_n(16);              // c=20
    chk(buzzer && strobe, "R9 buzzer and strobe toggle", {buzzer, strobe}, 2'b11);
    wait_n(16);              // c=36
    chk(!buzzer && !strobe, "R9 second toggle", {buzzer, strobe}, 2'b00);
    wait_n(4);               // c=40
    send_rx(8'hC3); distress_btn = 1'b1;
    send_rx(BOOT_B);
    wait_n(40);              // c=82
    chk(hs_cnt == base + 1 && !vibe, "R7 received bytes ignored in distress", hs_cnt, base + 1);
    distress_btn = 1'b0;
    wait_n(82);              // c=164
    chk(hs_cnt == base + 2 && hs_last == ALARM_B && lamp_red, "R8 alarm repeated after 5 s", hs_cnt, base + 2);

    // Simultaneous button edge and alarm byte
    go_active();
    distress_btn = 1'b1;
    wait_n(2);
    send_rx(8'hC0);          // c=1
    wait_n(19);              // c=20
    chk(buzzer && !vibe && lamp_red, "R11 distress wins over alarm byte", {buzzer, vibe, lamp_red}, 3'b101);
    distress_btn = 1'b0;

    // Reset clears distress
    do_reset();
    radio_ready = 1'b0;
    wait_n(1);
    chk(lamp_red && !buzzer && !strobe && !tx_valid, "R12 R7 reset clears distress", {lamp_red, buzzer, tx_valid}, 3'b100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule